// File: doc/BRIEF.md
# Scatter Segment to Descriptor Table Splitter

This block turns a list of physical memory segments, each given as a start address and a byte length, into the descriptor table that a bus-master disk DMA engine walks. Each descriptor is two 32-bit words: an address word, then a control word that holds a 16-bit byte count and, in bit 31, an end-of-table mark. The block writes the words one per cycle through a word-wide write port into an external descriptor memory. It cuts every segment so that no descriptor crosses a 64 KB address boundary.

Segments arrive on a valid/ready handshake, with a last flag on the final segment of a list. Segments of zero length are skipped. Once the final descriptor has been written, the block rewrites that descriptor's control word with the end mark set. It then raises a one-cycle done pulse, together with the number of descriptors built and an error flag. A count of zero with the error flag set tells software to use programmed I/O for the request instead. That result is given for an empty list, for a list that needs more descriptors than the table holds, and for a misaligned segment in word-count mode.

Two configuration inputs must be held stable for a whole list. The first is a half-split option for hosts that misread a zero count. The second is an alternate word-count encoding for hosts that need 32-bit aligned buffers.

Top module: `prd_splitter`

## Requirements
- R1: Each descriptor covers min(remaining segment bytes, 0x10000 − address[15:0]) bytes. No descriptor crosses a 64 KB boundary. The next descriptor starts at the previous address plus that length.
- R2: In byte mode (cfg_word_mode=0), control bits 15:0 hold the low 16 bits of the piece length and bits 30:16 are zero. With cfg_half_split=0, a full 64 KB piece gives count 0x0000.
- R3: With cfg_half_split=1 in byte mode, a 64 KB piece at address A becomes two descriptors: count 0x8000 at A, then count 0x8000 at A+0x8000.
- R4: Descriptor k has its address word at word index 2k and its control word at index 2k+1. Descriptors are numbered from 0 in order across all segments of the list.
- R5: Only the last descriptor of a successful list has control bit 31 set. It is written in a separate rewrite of that control word, one cycle before done.
- R6: If a list needs more than MAX_ENTRIES descriptors, the result is count 0 with the error flag set. The block still accepts and discards the rest of the list up to its last segment, and the next list is processed normally. Exactly MAX_ENTRIES descriptors is a success.
- R7: Zero-length segments produce no descriptor. A list that yields no descriptor ends with count 0 and the error flag set.
- R8: In word mode (cfg_word_mode=1), the control word is ((bytes/4)−1) in bits 31:16 with bits 15:0 zero, and no half split is applied. A segment whose address or length is not a multiple of 4 gives count 0 and the error flag set.
- R9: job_done is a one-cycle pulse, and job_count and job_err are valid in that cycle. seg_ready is low and no write occurs while descriptors are being built.
- R10: After reset, seg_ready is 1 and job_done and dt_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half_split | input | 1 | Split full 64 KB pieces into two 32 KB descriptors |
| cfg_word_mode | input | 1 | Word-count control encoding with 32-bit alignment |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high together with seg_valid |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the list |
| dt_we | output | 1 | Descriptor memory word write |
| dt_widx | output | IDX_W | Word index (2k address, 2k+1 control) |
| dt_wdata | output | 32 | Word written |
| job_done | output | 1 | One-cycle completion pulse |
| job_count | output | CNT_W | Descriptors built (0 on failure) |
| job_err | output | 1 | List failed, fall back to programmed I/O |

## Verification
The main function is tried with one table of single-segment lists. It holds a segment inside one 64 KB window, one that straddles a boundary, an exact 64 KB aligned piece with and without the half split, and an unaligned piece followed by a full window. It also holds word-mode pieces, both aligned to the window and straddling it. Together these separate the boundary cut from the 64 KB count wrap, and the split from the word encoding. Directed lists follow. A multi-segment list with a zero-length middle entry checks numbering and skipping. Lists of exactly the table limit and of one byte over it separate success from overflow, and the overflow list also checks that the trailing segment is drained. An empty list and a misaligned word-mode segment check the fallback result.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_END,
    ST_FINISH,
    ST_DRAIN
  } prd_state_e;

  localparam logic [16:0] WINDOW = 17'h10000;
  localparam logic [16:0] HALF   = 17'h08000;

  // bytes left before the next 64 KB boundary
  function automatic logic [16:0] boundary_gap(input logic [15:0] lo);
    return WINDOW - {1'b0, lo};
  endfunction

  // control word for one piece (end mark clear)
  function automatic logic [31:0] ctrl_word(input logic [16:0] piece,
                                            input logic word_mode);
    logic [16:0] quads;
    quads = (piece >> 2) - 17'd1;
    if (word_mode) return {quads[15:0], 16'h0000};
    return {16'h0000, piece[15:0]};
  endfunction

endpackage

// File: rtl/prd_piece_calc.sv
module prd_piece_calc
  import prd_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic [15:0]      addr_lo,
  input  logic [LEN_W-1:0] remain,
  input  logic             half_split,
  input  logic             word_mode,
  output logic [16:0]      piece,
  output logic [31:0]      ctrl
);
  logic [16:0] gap;
  logic [16:0] raw;

  always_comb begin
    gap = boundary_gap(addr_lo);
    if (remain < LEN_W'(gap)) raw = remain[16:0];
    else                      raw = gap;
    if (half_split && !word_mode && raw == WINDOW) piece = HALF;
    else                                           piece = raw;
    ctrl = ctrl_word(piece, word_mode);
  end
endmodule

// File: rtl/prd_slot_counter.sv
module prd_slot_counter #(
  parameter int MAX_ENTRIES = 256,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + CNT_W'(1);
  end
  assign full = (cnt == CNT_W'(MAX_ENTRIES));
endmodule

// File: rtl/prd_splitter.sv
module prd_splitter
  import prd_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  parameter int LEN_W = 24,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W = $clog2(2 * MAX_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_half_split,
  input  logic             cfg_word_mode,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  output logic             dt_we,
  output logic [IDX_W-1:0] dt_widx,
  output logic [31:0]      dt_wdata,
  output logic             job_done,
  output logic [CNT_W-1:0] job_count,
  output logic             job_err
);
  prd_state_e       st;
  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] remain;
  logic             last_q;
  logic             err_q;
  logic [31:0]      ctrl_q;
  logic [IDX_W-2:0] slot_q;

  // named internal events for the checker
  logic             seg_take;
  logic             misalign;
  logic             emit_addr;
  logic             emit_ctrl;
  logic             emit_end;
  logic             seg_spent;
  logic [16:0]      piece;
  logic [31:0]      piece_ctrl;
  logic [CNT_W-1:0] cnt;
  logic             full;

  prd_piece_calc #(.LEN_W(LEN_W)) u_calc (
    .addr_lo    (cur_addr[15:0]),
    .remain     (remain),
    .half_split (cfg_half_split),
    .word_mode  (cfg_word_mode),
    .piece      (piece),
    .ctrl       (piece_ctrl)
  );

  prd_slot_counter #(.MAX_ENTRIES(MAX_ENTRIES)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (job_done),
    .inc   (emit_ctrl),
    .cnt   (cnt),
    .full  (full)
  );

  assign seg_ready = (st == ST_IDLE) || (st == ST_DRAIN);
  assign seg_take  = seg_valid && seg_ready;
  assign misalign  = cfg_word_mode && ((seg_addr[1:0] != 2'b00) || (seg_len[1:0] != 2'b00));
  assign emit_addr = (st == ST_ADDR) && !full;
  assign emit_ctrl = (st == ST_CTRL);
  assign emit_end  = (st == ST_END) && (cnt != '0);
  assign seg_spent = (remain == LEN_W'(piece));
  assign job_done  = (st == ST_FINISH);
  assign job_err   = err_q;
  assign job_count = err_q ? '0 : cnt;

  always_comb begin
    dt_we    = emit_addr || emit_ctrl || emit_end;
    dt_widx  = '0;
    dt_wdata = '0;
    if (emit_addr) begin
      dt_widx  = {cnt[IDX_W-2:0], 1'b0};
      dt_wdata = cur_addr;
    end else if (emit_ctrl) begin
      dt_widx  = {cnt[IDX_W-2:0], 1'b1};
      dt_wdata = piece_ctrl;
    end else if (emit_end) begin
      dt_widx  = {slot_q, 1'b1};
      dt_wdata = ctrl_q | 32'h8000_0000;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      last_q   <= 1'b0;
      err_q    <= 1'b0;
      ctrl_q   <= '0;
      slot_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (seg_take) begin
          if (seg_len == '0) begin
            st <= seg_last ? ST_END : ST_IDLE;
          end else if (misalign) begin
            err_q <= 1'b1;
            st    <= seg_last ? ST_FINISH : ST_DRAIN;
          end else begin
            cur_addr <= seg_addr;
            remain   <= seg_len;
            last_q   <= seg_last;
            st       <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (full) begin
            err_q <= 1'b1;
            st    <= last_q ? ST_FINISH : ST_DRAIN;
          end else begin
            st <= ST_CTRL;
          end
        end
        ST_CTRL: begin
          ctrl_q   <= piece_ctrl;
          slot_q   <= cnt[IDX_W-2:0];
          cur_addr <= cur_addr + 32'(piece);
          remain   <= remain - LEN_W'(piece);
          if (seg_spent) st <= last_q ? ST_END : ST_IDLE;
          else           st <= ST_ADDR;
        end
        ST_END: begin
          if (cnt == '0) err_q <= 1'b1;
          st <= ST_FINISH;
        end
        ST_FINISH: begin
          err_q <= 1'b0;
          st    <= ST_IDLE;
        end
        ST_DRAIN: if (seg_take && seg_last) st <= ST_FINISH;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_splitter_chk.sv
module prd_splitter_chk #(
  parameter int MAX_ENTRIES = 256,
  parameter int CNT_W = 9,
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_half_split,
  input logic             cfg_word_mode,
  input logic             seg_ready,
  input logic             dt_we,
  input logic [IDX_W-1:0] dt_widx,
  input logic [31:0]      dt_wdata,
  input logic             job_done,
  input logic [CNT_W-1:0] job_count,
  input logic             job_err,
  input logic             emit_ctrl,
  input logic [16:0]      piece,
  input logic [31:0]      cur_addr
);
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    emit_ctrl |-> ({1'b0, cur_addr[15:0]} + piece) <= 17'h10000); // R1

  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    emit_ctrl && cfg_half_split && !cfg_word_mode |-> dt_wdata[15:0] != 16'h0000); // R3

  AST_END_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dt_we && dt_widx[0] && dt_wdata[31] |=> job_done); // R5

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    job_done && job_err |-> job_count == '0); // R6

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    job_count <= CNT_W'(MAX_ENTRIES)); // R6

  AST_WORD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dt_we && dt_widx[0] && cfg_word_mode |-> dt_wdata[15:0] == 16'h0000); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done); // R9

  AST_NO_WRITE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    seg_ready |-> !dt_we); // R9
endmodule

bind prd_splitter prd_splitter_chk #(
  .MAX_ENTRIES (MAX_ENTRIES),
  .CNT_W       (CNT_W),
  .IDX_W       (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_half_split (cfg_half_split),
  .cfg_word_mode  (cfg_word_mode),
  .seg_ready      (seg_ready),
  .dt_we          (dt_we),
  .dt_widx        (dt_widx),
  .dt_wdata       (dt_wdata),
  .job_done       (job_done),
  .job_count      (job_count),
  .job_err        (job_err),
  .emit_ctrl      (emit_ctrl),
  .piece          (piece),
  .cur_addr       (cur_addr)
);

// File: tb/prd_splitter_test.sv
`timescale 1ns/1ps
module prd_splitter_test;
  localparam int MAXE  = 8;
  localparam int LEN_W = 24;
  localparam int CNT_W = $clog2(MAXE + 1);
  localparam int IDX_W = $clog2(2 * MAXE);
  localparam int NW    = 2 * MAXE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_half_split = 1'b0, cfg_word_mode = 1'b0;
  logic seg_valid = 1'b0, seg_last = 1'b0;
  logic [31:0] seg_addr = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic seg_ready, dt_we, job_done, job_err;
  logic [IDX_W-1:0] dt_widx;
  logic [31:0] dt_wdata;
  logic [CNT_W-1:0] job_count;

  always #2.5 clk = ~clk;

  prd_splitter #(.MAX_ENTRIES(MAXE), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_half_split(cfg_half_split),
    .cfg_word_mode(cfg_word_mode), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .dt_we(dt_we), .dt_widx(dt_widx), .dt_wdata(dt_wdata),
    .job_done(job_done), .job_count(job_count), .job_err(job_err)
  );

  logic [31:0] mem [NW+1];
  always @(posedge clk) if (dt_we) mem[dt_widx] <= dt_wdata;

  int checks = 0, failures = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  // segment list and independent reference
  logic [31:0] sa [4];
  logic [31:0] sl [4];
  logic [31:0] rw [NW+2];
  int ref_n;
  bit ref_err;

  task automatic build_ref(input int n, input bit half, input bit word);
    longint a, rem, edge_b, take;
    ref_n = 0; ref_err = 0;
    for (int s = 0; s < n; s++) begin
      a = sa[s]; rem = sl[s];
      if (rem != 0 && word && ((a % 4) != 0 || (rem % 4) != 0)) ref_err = 1;
      while (rem > 0 && !ref_err) begin
        edge_b = ((a / 65536) + 1) * 65536;
        take = (rem < edge_b - a) ? rem : edge_b - a;
        if (half && !word && take == 65536) take = 32768;
        if (ref_n >= MAXE) begin ref_err = 1; break; end
        rw[2*ref_n] = 32'(a);
        rw[2*ref_n+1] = word ? 32'(((take / 4) - 1) * 65536) : 32'(take % 65536);
        ref_n++;
        a = a + take; rem = rem - take;
      end
    end
    if (ref_n == 0) ref_err = 1;
    if (!ref_err) rw[2*ref_n-1] = rw[2*ref_n-1] | 32'h8000_0000;
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] l, input bit last);
    seg_valid = 1'b1; seg_addr = a; seg_len = LEN_W'(l); seg_last = last;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0; seg_last = 1'b0;
  endtask

  task automatic run_job(input string req, input int n, input bit half, input bit word,
                         output int got_n);
    logic [CNT_W-1:0] c; logic e;
    cfg_half_split = half; cfg_word_mode = word;
    build_ref(n, half, word);
    for (int i = 0; i <= NW; i++) mem[i] = 32'hA5A5_A5A5;
    for (int s = 0; s < n; s++) send(sa[s], sl[s], s == n - 1);
    while (!job_done) @(negedge clk);
    c = job_count; e = job_err; got_n = int'(c);
    chk({req, " count"}, 32'(c), ref_err ? 32'd0 : 32'(ref_n));
    chk({req, " err"}, 32'(e), 32'(ref_err));
    if (!ref_err)
      for (int i = 0; i < 2 * ref_n; i++) chk({req, " word"}, mem[i], rw[i]);
    @(negedge clk);
    chk("R9 done pulse", 32'(job_done), 32'd0);
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] l;
    logic        half;
    logic        word;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_1000, 32'h0000_0800, 1'b0, 1'b0, 8'd1},
    '{32'h0001_F000, 32'h0000_2000, 1'b0, 1'b0, 8'd2},
    '{32'h0002_0000, 32'h0001_0000, 1'b0, 1'b0, 8'd1},
    '{32'h0002_0000, 32'h0001_0000, 1'b1, 1'b0, 8'd2},
    '{32'h0003_8000, 32'h0001_8000, 1'b1, 1'b0, 8'd3},
    '{32'h0005_0000, 32'h0001_0000, 1'b0, 1'b1, 8'd1},
    '{32'h0006_FFF0, 32'h0000_0020, 1'b0, 1'b1, 8'd2},
    '{32'h0007_0001, 32'h0000_0003, 1'b0, 1'b0, 8'd1}
  };

  initial begin
    int got;
    repeat (3) @(negedge clk);
    chk("R10 ready", 32'(seg_ready), 32'd1);
    chk("R10 done", 32'(job_done), 32'd0);
    chk("R10 we", 32'(dt_we), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R1 boundary cut, R4 layout, R5 end mark
    for (int v = 0; v < 8; v++) begin
      sa[0] = VECS[v].a; sl[0] = VECS[v].l;
      run_job("R1 R4 R5 table", 1, VECS[v].half, VECS[v].word, got);
      chk("R1 table count", 32'(got), 32'(VECS[v].exp));
    end

    // R2: full 64 KB piece without split wraps the count to zero
    sa[0] = 32'h0002_0000; sl[0] = 32'h1_0000;
    run_job("R2", 1, 1'b0, 1'b0, got);
    chk("R2 ctrl", mem[1], 32'h8000_0000);

    // R3: half split words
    run_job("R3", 1, 1'b1, 1'b0, got);
    chk("R3 a0", mem[0], 32'h0002_0000);
    chk("R3 c0", mem[1], 32'h0000_8000);
    chk("R3 a1", mem[2], 32'h0002_8000);
    chk("R3 c1", mem[3], 32'h8000_8000);

    // R8: word mode encoding, split ignored, misalignment
    sa[0] = 32'h0005_0000; sl[0] = 32'h1_0000;
    run_job("R8", 1, 1'b1, 1'b1, got);
    chk("R8 ctrl", mem[1], 32'hBFFF_0000);
    sa[0] = 32'h0005_0000; sl[0] = 32'h6;
    run_job("R8 misalign", 1, 1'b0, 1'b1, got);
    chk("R8 misalign count", 32'(got), 32'd0);

    // R4 + R7: multi-segment list with a zero-length middle entry
    sa[0] = 32'h0000_1000; sl[0] = 32'h100;
    sa[1] = 32'h0000_3000; sl[1] = 32'h0;
    sa[2] = 32'h00FF_FF00; sl[2] = 32'h200;
    run_job("R4 R7 multi", 3, 1'b0, 1'b0, got);
    chk("R4 multi count", 32'(got), 32'd3);
    chk("R4 third addr", mem[4], 32'h0100_0000);
    chk("R5 mid ctrl clear", mem[3], 32'h0000_0100);

    // R6: exact limit, then one byte over with drained tail segment
    sa[0] = 32'h0008_0000; sl[0] = 32'h8_0000;
    run_job("R6 exact", 1, 1'b0, 1'b0, got);
    chk("R6 exact count", 32'(got), 32'd8);
    sa[0] = 32'h0008_0000; sl[0] = 32'h8_0001;
    sa[1] = 32'h0000_0000; sl[1] = 32'h10;
    run_job("R6 overflow", 2, 1'b0, 1'b0, got);
    chk("R6 overflow count", 32'(got), 32'd0);
    sa[0] = 32'h0000_2000; sl[0] = 32'h40;
    run_job("R6 after overflow", 1, 1'b0, 1'b0, got);
    chk("R6 after count", 32'(got), 32'd1);

    // R7: empty list
    sa[0] = 32'h0000_4000; sl[0] = 32'h0;
    run_job("R7 empty", 1, 1'b0, 1'b0, got);
    chk("R7 untouched", mem[1], 32'hA5A5_A5A5);

    summary();
  end
endmodule